// File: doc/BRIEF.md
# Multi-warp instruction fetch controller

This block decides, cycle by cycle, which hardware warp sends the next request to the instruction cache. It holds a one-entry fetch buffer (valid, PC, byte count, warp index) that the decode stage drains through `buf_pop`. While the buffer is empty, a fill returning from an earlier cache miss is taken first. Otherwise a rotating scan looks for a warp that is not finished, is not waiting on a miss and has an empty instruction buffer. The scan starts at the warp after the last one fetched.

A request carries the warp PC offset by a fixed program-memory base. Its size is 16 bytes, cut short so that it never crosses a cache line. The cache answers in the same cycle with a status code. A hit loads the fetch buffer. A miss marks the warp as miss-pending until its fill returns. A reservation failure changes nothing except the rotation pointer. The block owns each warp's miss-pending flag and a last-fetch timestamp taken from a free-running cycle counter. A perfect-cache input makes every request count as a hit.

Top module: `warp_fetch_ctrl`

## Requirements
- R1: After reset the fetch buffer is empty, no warp is miss-pending, every timestamp reads 0, and the rotation pointer holds the highest warp index, so warp 0 is scanned first.
- R2: When the buffer is empty and no fill is offered, `req_valid` rises in the same cycle for the first eligible warp, scanning from last-fetched+1 upward and wrapping modulo the warp count. A warp is eligible when it is not done, not miss-pending and has an empty I-buffer. At most one request goes out per cycle, and `req_valid` is 0 when no warp is eligible.
- R3: `req_bytes` is 16. When (PC mod line size) + 16 exceeds the 128-byte line, it is the line size minus that offset instead (offset 112 gives 16, offset 120 gives 8, offset 124 gives 4). `req_addr` equals the PC plus the program base.
- R4: The status code 0 means hit. A request answered with a hit loads the buffer at the next clock edge with the warp's PC, the request size and the warp index, and sets it valid.
- R5: The status code 1 means miss. A miss sets the warp's miss-pending flag at the next edge and leaves the buffer empty.
- R6: The status code 2 (and 3) means reservation failure. It leaves the buffer, the miss flags and the timestamps untouched, but the rotation pointer still moves to the selected warp.
- R7: A fill offered while the buffer is empty is accepted (`fill_ack`=1) with no request in that cycle. At the next edge the owning warp's miss flag is cleared and the buffer is loaded with that warp's PC, `fill_bytes` and the warp index. The rotation pointer does not move.
- R8: While the buffer is valid, neither a request nor a fill acceptance happens. `buf_pop` empties the buffer at the next edge.
- R9: A hit, a miss and an accepted fill each write the current cycle count into the warp's timestamp. The count is 0 in the first cycle after reset is released and rises by 1 every cycle.
- R10: With `perfect_icache`=1, every request is treated as a hit whatever `req_status` says.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| perfect_icache | input | 1 | Treat every request as a hit |
| warp_pc | input | NW*PCW | Current PC of each warp, warp i at bits [i*PCW +: PCW] |
| warp_done | input | NW | Warp has finished |
| warp_ibuf_empty | input | NW | Warp instruction buffer is empty |
| req_valid | output | 1 | Cache request this cycle |
| req_addr | output | PCW | Request address (PC + program base) |
| req_bytes | output | BW | Request size in bytes |
| req_warp | output | IW | Requesting warp |
| req_status | input | 2 | Same-cycle reply: 0 hit, 1 miss, 2/3 reservation failure |
| fill_valid | input | 1 | A miss fill is ready |
| fill_warp | input | IW | Warp that owns the fill |
| fill_bytes | input | BW | Size of the fill |
| fill_ack | output | 1 | Fill taken this cycle |
| buf_valid | output | 1 | Fetch buffer holds an entry |
| buf_pc | output | PCW | Buffered PC |
| buf_bytes | output | BW | Buffered byte count |
| buf_warp | output | IW | Buffered warp index |
| buf_pop | input | 1 | Decode consumes the buffer entry |
| warp_miss_pend | output | NW | Per-warp miss-pending flags |
| warp_last_fetch | output | NW*TSW | Per-warp last-fetch timestamps, warp i at [i*TSW +: TSW] |

## Verification
The request fields and `fill_ack` are combinational, so the bench checks them 1 ns after it changes the inputs at the falling edge, in the same cycle. Buffer contents, miss flags and timestamps are registered once, so they are checked at the next falling edge. A buffer entry is visible for exactly one cycle, because the monitor pops it as soon as it sees it. Between stimuli the bench marks every warp done, so that no stray request shifts the rotation or the expected timestamps. The timestamps are compared against the bench's own cycle counter, read in the request cycle.

// File: rtl/wfc_pkg.sv
// Shared types for the warp fetch controller.
// Assumes the cache status reply is a 2-bit code.
package wfc_pkg;
    typedef enum logic [1:0] {
        ST_HIT     = 2'd0,
        ST_MISS    = 2'd1,
        ST_RSVFAIL = 2'd2,
        ST_RSVALT  = 2'd3
    } cache_status_e;
endpackage

// File: rtl/wfc_rr_arbiter.sv
// Rotating first-eligible picker with its own last-granted pointer.
// Scans from pointer+1, wrapping modulo NW. The pointer moves only on advance.
module wfc_rr_arbiter #(
    parameter int NW = 8,
    localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NW-1:0] elig,
    input  logic          advance,
    output logic          grant_valid,
    output logic [IW-1:0] grant_idx
);
    logic [IW-1:0] last_q;
    int            cand;

    // Find the first eligible warp after the last one granted.
    always_comb begin
        grant_valid = 1'b0;
        grant_idx   = '0;
        cand        = 0;
        for (int i = 0; i < NW; i++) begin
            cand = (int'(last_q) + 1 + i) % NW;
            if (!grant_valid && elig[cand]) begin
                grant_valid = 1'b1;
                grant_idx   = IW'(cand);
            end
        end
    end

    // Remember the most recently selected warp; the reset value puts warp 0 first.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= IW'(NW - 1);
        else if (advance)
            last_q <= grant_idx;
    end

    // R2: a grant always names an eligible warp
    p_grant_elig_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> elig[grant_idx]);
endmodule

// File: rtl/wfc_fetch_sizer.sv
// Computes the request address and size from a warp PC.
// Assumes LINE_BYTES is a power of two and FETCH_BYTES <= LINE_BYTES.
module wfc_fetch_sizer #(
    parameter int          PCW         = 32,
    parameter int          LINE_BYTES  = 128,
    parameter int          FETCH_BYTES = 16,
    parameter int unsigned PROG_BASE   = 32'h0000_0000,
    localparam int LW = $clog2(LINE_BYTES),
    localparam int BW = LW + 1
) (
    input  logic [PCW-1:0] pc,
    output logic [PCW-1:0] addr,
    output logic [BW-1:0]  bytes
);
    logic [LW-1:0] offset;
    int            off_i;

    assign offset = pc[LW-1:0];
    assign addr   = pc + PCW'(PROG_BASE);

    // Trim the request so it stops at the end of the cache line.
    always_comb begin
        off_i = int'(offset);
        if (off_i + FETCH_BYTES > LINE_BYTES)
            bytes = BW'(LINE_BYTES - off_i);
        else
            bytes = BW'(FETCH_BYTES);
    end
endmodule

// File: rtl/wfc_warp_state.sv
// Per-warp miss-pending flags and last-fetch timestamps.
// Assumes set and clear never target the same warp in one cycle.
module wfc_warp_state #(
    parameter int NW  = 8,
    parameter int TSW = 64,
    localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            set_en,
    input  logic [IW-1:0]   set_idx,
    input  logic            clr_en,
    input  logic [IW-1:0]   clr_idx,
    input  logic            stamp_en,
    input  logic [IW-1:0]   stamp_idx,
    input  logic [TSW-1:0]  now,
    output logic [NW-1:0]   miss_pend,
    output logic [NW*TSW-1:0] stamps
);
    logic [TSW-1:0] stamp_q [NW];

    for (genvar w = 0; w < NW; w++) begin : g_warp
        // Track whether this warp is waiting on an instruction miss.
        always_ff @(posedge clk) begin
            if (!rst_n)
                miss_pend[w] <= 1'b0;
            else if (set_en && set_idx == IW'(w))
                miss_pend[w] <= 1'b1;
            else if (clr_en && clr_idx == IW'(w))
                miss_pend[w] <= 1'b0;
        end

        // Record the cycle of this warp's latest fetch event.
        always_ff @(posedge clk) begin
            if (!rst_n)
                stamp_q[w] <= '0;
            else if (stamp_en && stamp_idx == IW'(w))
                stamp_q[w] <= now;
        end

        assign stamps[w*TSW +: TSW] = stamp_q[w];
    end

    // R9: a stamped warp holds the cycle value of the stamping cycle
    p_stamp_value_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stamp_en |=> stamp_q[$past(stamp_idx)] == $past(now));
endmodule

// File: rtl/warp_fetch_ctrl.sv
// Multi-warp instruction fetch controller.
// Owns a one-entry fetch buffer and picks at most one warp per cycle for a cache request.
// Assumes the cache replies to a request combinationally in the same cycle.
module warp_fetch_ctrl
    import wfc_pkg::*;
#(
    parameter int          NW          = 8,
    parameter int          PCW         = 32,
    parameter int          LINE_BYTES  = 128,
    parameter int          FETCH_BYTES = 16,
    parameter int          TSW         = 64,
    parameter int unsigned PROG_BASE   = 32'h0000_1000,
    localparam int IW = (NW > 1) ? $clog2(NW) : 1,
    localparam int BW = $clog2(LINE_BYTES) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              perfect_icache,
    input  logic [NW*PCW-1:0] warp_pc,
    input  logic [NW-1:0]     warp_done,
    input  logic [NW-1:0]     warp_ibuf_empty,
    output logic              req_valid,
    output logic [PCW-1:0]    req_addr,
    output logic [BW-1:0]     req_bytes,
    output logic [IW-1:0]     req_warp,
    input  logic [1:0]        req_status,
    input  logic              fill_valid,
    input  logic [IW-1:0]     fill_warp,
    input  logic [BW-1:0]     fill_bytes,
    output logic              fill_ack,
    output logic              buf_valid,
    output logic [PCW-1:0]    buf_pc,
    output logic [BW-1:0]     buf_bytes,
    output logic [IW-1:0]     buf_warp,
    input  logic              buf_pop,
    output logic [NW-1:0]     warp_miss_pend,
    output logic [NW*TSW-1:0] warp_last_fetch
);
    logic          buf_free;
    logic          scan_en;
    logic [NW-1:0] elig;
    logic          grant_valid;
    logic [IW-1:0] grant_idx;
    logic [PCW-1:0] sel_pc;
    logic [PCW-1:0] fill_pc;
    cache_status_e  st_eff;
    logic          is_hit;
    logic          is_miss;
    logic [TSW-1:0] cyc_q;

    // Decide whether this cycle serves a fill, scans for a request, or idles.
    always_comb begin
        buf_free = !buf_valid;
        fill_ack = buf_free && fill_valid;
        scan_en  = buf_free && !fill_valid;
        elig     = ~warp_done & ~warp_miss_pend & warp_ibuf_empty & {NW{scan_en}};
    end

    wfc_rr_arbiter #(.NW(NW)) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .elig        (elig),
        .advance     (grant_valid),
        .grant_valid (grant_valid),
        .grant_idx   (grant_idx)
    );

    assign sel_pc    = warp_pc[grant_idx*PCW +: PCW];
    assign fill_pc   = warp_pc[fill_warp*PCW +: PCW];
    assign req_valid = grant_valid;
    assign req_warp  = grant_idx;

    wfc_fetch_sizer #(
        .PCW         (PCW),
        .LINE_BYTES  (LINE_BYTES),
        .FETCH_BYTES (FETCH_BYTES),
        .PROG_BASE   (PROG_BASE)
    ) u_size (
        .pc    (sel_pc),
        .addr  (req_addr),
        .bytes (req_bytes)
    );

    // Resolve the cache outcome, with the perfect-cache override.
    always_comb begin
        st_eff  = perfect_icache ? ST_HIT : cache_status_e'(req_status);
        is_hit  = req_valid && (st_eff == ST_HIT);
        is_miss = req_valid && (st_eff == ST_MISS);
    end

    // Free-running cycle count used for timestamps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cyc_q <= '0;
        else
            cyc_q <= cyc_q + 1'b1;
    end

    // Load the fetch buffer from a fill or a hit, and empty it on pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_valid <= 1'b0;
            buf_pc    <= '0;
            buf_bytes <= '0;
            buf_warp  <= '0;
        end else if (fill_ack) begin
            buf_valid <= 1'b1;
            buf_pc    <= fill_pc;
            buf_bytes <= fill_bytes;
            buf_warp  <= fill_warp;
        end else if (is_hit) begin
            buf_valid <= 1'b1;
            buf_pc    <= sel_pc;
            buf_bytes <= req_bytes;
            buf_warp  <= grant_idx;
        end else if (buf_pop) begin
            buf_valid <= 1'b0;
        end
    end

    wfc_warp_state #(.NW(NW), .TSW(TSW)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (is_miss),
        .set_idx   (grant_idx),
        .clr_en    (fill_ack),
        .clr_idx   (fill_warp),
        .stamp_en  (is_hit || is_miss || fill_ack),
        .stamp_idx (fill_ack ? fill_warp : grant_idx),
        .now       (cyc_q),
        .miss_pend (warp_miss_pend),
        .stamps    (warp_last_fetch)
    );

    // R7: a fill and a new request never share a cycle
    p_one_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && fill_ack));

    // R8: a held entry blocks both requests and fills
    p_busy_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_valid |-> (!req_valid && !fill_ack));

    // R3: request size stays between 1 and the nominal fetch size
    p_size_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req_bytes != '0 && req_bytes <= BW'(FETCH_BYTES)));

    // R4: a hit leaves the buffer valid for the requesting warp
    p_hit_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        is_hit |=> (buf_valid && buf_warp == $past(grant_idx)));

    // R5: a miss marks its warp pending and leaves the buffer empty
    p_miss_mark_r5: assert property (@(posedge clk) disable iff (!rst_n)
        is_miss |=> (warp_miss_pend[$past(grant_idx)] && !buf_valid));

    // R6: a reservation failure loads nothing
    p_rsv_noload_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !is_hit && !is_miss) |=> !buf_valid);

    // R7: an accepted fill clears its warp's pending flag
    p_fill_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fill_ack |=> (!warp_miss_pend[$past(fill_warp)] && buf_valid));
endmodule

// File: tb/warp_fetch_ctrl_tb.sv
// Scoreboard bench: driver tasks queue expected buffer entries, a monitor compares them.
module warp_fetch_ctrl_tb;
    localparam int NW = 8;
    localparam int PCW = 32;
    localparam int TSW = 64;
    localparam int IW = 3;
    localparam int BW = 8;
    localparam logic [31:0] BASE = 32'h0000_1000;

    typedef struct {
        logic [PCW-1:0] pc;
        logic [BW-1:0]  bytes;
        logic [IW-1:0]  warp;
        string          tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              perfect_icache = 1'b0;
    logic [NW*PCW-1:0] warp_pc;
    logic [NW-1:0]     warp_done = '1;
    logic [NW-1:0]     warp_ibuf_empty = '1;
    logic              req_valid;
    logic [PCW-1:0]    req_addr;
    logic [BW-1:0]     req_bytes;
    logic [IW-1:0]     req_warp;
    logic [1:0]        req_status = 2'd0;
    logic              fill_valid = 1'b0;
    logic [IW-1:0]     fill_warp = '0;
    logic [BW-1:0]     fill_bytes = '0;
    logic              fill_ack;
    logic              buf_valid;
    logic [PCW-1:0]    buf_pc;
    logic [BW-1:0]     buf_bytes;
    logic [IW-1:0]     buf_warp;
    logic              buf_pop = 1'b0;
    logic [NW-1:0]     warp_miss_pend;
    logic [NW*TSW-1:0] warp_last_fetch;

    int     n_cmp = 0;
    int     n_mis = 0;
    bit     done_flag = 1'b0;
    logic [TSW-1:0] tb_cyc;
    exp_t   exp_q [$];
    logic [PCW-1:0] pcs [NW];

    warp_fetch_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .perfect_icache(perfect_icache),
        .warp_pc(warp_pc), .warp_done(warp_done), .warp_ibuf_empty(warp_ibuf_empty),
        .req_valid(req_valid), .req_addr(req_addr), .req_bytes(req_bytes),
        .req_warp(req_warp), .req_status(req_status), .fill_valid(fill_valid),
        .fill_warp(fill_warp), .fill_bytes(fill_bytes), .fill_ack(fill_ack),
        .buf_valid(buf_valid), .buf_pc(buf_pc), .buf_bytes(buf_bytes),
        .buf_warp(buf_warp), .buf_pop(buf_pop), .warp_miss_pend(warp_miss_pend),
        .warp_last_fetch(warp_last_fetch)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) tb_cyc <= '0;
        else        tb_cyc <= tb_cyc + 1'b1;
    end

    initial begin
        for (int i = 0; i < NW; i++) pcs[i] = 32'h0000_2000 + 32'(i) * 32'h100;
        pcs[0] = 32'h0000_2070;
        pcs[5] = 32'h0000_2578;
        pcs[7] = 32'h0000_277C;
        for (int i = 0; i < NW; i++) warp_pc[i*PCW +: PCW] = pcs[i];
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_mis++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [TSW-1:0] ts_of(input int w);
        return warp_last_fetch[w*TSW +: TSW];
    endfunction

    // Monitor: pops and compares each buffer entry the cycle it appears.
    always @(negedge clk) begin
        if (rst_n && buf_valid) begin
            if (exp_q.size() == 0) begin
                chk("R4 unexpected buffer entry", 64'd1, 64'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk({e.tag, " buf_pc"}, 64'(buf_pc), 64'(e.pc));
                chk({e.tag, " buf_bytes"}, 64'(buf_bytes), 64'(e.bytes));
                chk({e.tag, " buf_warp"}, 64'(buf_warp), 64'(e.warp));
            end
            buf_pop = 1'b1;
        end else begin
            buf_pop = 1'b0;
        end
    end

    // Driver: one request cycle with the given done mask and cache reply.
    task automatic issue(input logic [NW-1:0] dmask, input logic [1:0] st, input int ew,
                         input int eb, input bit eload, input bit emiss, input bit estamp,
                         input string tag);
        logic [TSW-1:0] now;
        logic [TSW-1:0] old_ts;
        exp_t e;
        @(negedge clk);
        while (buf_valid) @(negedge clk);
        warp_done  = dmask;
        req_status = st;
        #1;
        now    = tb_cyc;
        old_ts = ts_of(ew);
        chk({tag, " req_valid"}, 64'(req_valid), 64'd1);
        chk({tag, " R2 req_warp"}, 64'(req_warp), 64'(ew));
        chk({tag, " R3 req_bytes"}, 64'(req_bytes), 64'(eb));
        chk({tag, " R3 req_addr"}, 64'(req_addr), 64'(pcs[ew] + BASE));
        if (eload) begin
            e.pc = pcs[ew]; e.bytes = BW'(eb); e.warp = IW'(ew); e.tag = tag;
            exp_q.push_back(e);
        end
        @(posedge clk);
        #1;
        warp_done = '1;
        @(negedge clk);
        chk({tag, " R5 miss_pend"}, 64'(warp_miss_pend[ew]), 64'(emiss));
        chk({tag, " R9 stamp"}, ts_of(ew), estamp ? now : old_ts);
        if (!eload) chk({tag, " R6 no load"}, 64'(buf_valid), 64'd0);
    endtask

    initial begin
        logic [TSW-1:0] now;
        exp_t e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        // R1: reset state
        chk("R1 buf_valid", 64'(buf_valid), 64'd0);
        chk("R1 miss_pend", 64'(warp_miss_pend), 64'd0);
        chk("R1 stamps", 64'(|warp_last_fetch), 64'd0);
        chk("R2 no eligible warp", 64'(req_valid), 64'd0);

        // R1 R4: first pick after reset is warp 0; offset 112 keeps 16 bytes
        issue(8'h00, 2'd0, 0, 16, 1, 0, 1, "R1 R4 hit w0");
        // R5: next warp misses
        issue(8'h00, 2'd1, 1, 16, 0, 1, 1, "R5 miss w1");
        // R6: reservation failure on warp 2
        issue(8'h00, 2'd2, 2, 16, 0, 0, 0, "R6 rsvfail w2");
        // R2 R3: skip done warp 3 and busy-ibuf warp 4, trim to 8 bytes
        warp_ibuf_empty = 8'b1110_1111;
        issue(8'b0000_1000, 2'd0, 5, 8, 1, 0, 1, "R2 R3 hit w5");
        warp_ibuf_empty = '1;

        // R7: a fill beats eligible warps
        @(negedge clk);
        while (buf_valid) @(negedge clk);
        warp_done  = 8'h00;
        fill_valid = 1'b1;
        fill_warp  = 3'd1;
        fill_bytes = 8'd12;
        #1;
        now = tb_cyc;
        chk("R7 fill_ack", 64'(fill_ack), 64'd1);
        chk("R7 no request", 64'(req_valid), 64'd0);
        e.pc = pcs[1]; e.bytes = 8'd12; e.warp = 3'd1; e.tag = "R7 fill w1";
        exp_q.push_back(e);
        @(negedge clk);
        #1;
        // R8: buffer held blocks fill and request
        chk("R8 no fill_ack", 64'(fill_ack), 64'd0);
        chk("R8 no request", 64'(req_valid), 64'd0);
        chk("R7 miss cleared", 64'(warp_miss_pend[1]), 64'd0);
        chk("R9 fill stamp", ts_of(1), now);
        fill_valid = 1'b0;
        warp_done  = '1;
        @(negedge clk);
        #1;
        chk("R8 pop empties", 64'(buf_valid), 64'd0);

        // R2 R3: pointer unchanged by fill; warp 6 done so warp 7 with 4 bytes
        issue(8'b0100_0000, 2'd0, 7, 4, 1, 0, 1, "R2 R3 hit w7");
        // R2: wrap to warp 0
        issue(8'h00, 2'd0, 0, 16, 1, 0, 1, "R2 wrap w0");
        // R10: perfect cache turns a miss reply into a hit
        perfect_icache = 1'b1;
        issue(8'h00, 2'd1, 1, 16, 1, 0, 1, "R10 perfect w1");
        perfect_icache = 1'b0;

        repeat (3) @(negedge clk);
        chk("R4 queue drained", 64'(exp_q.size()), 64'd0);
        done_flag = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done_flag) begin
            n_cmp++;
            n_mis++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
            $finish;
        end
    end
endmodule